// File: doc/BRIEF.md
# Instruction Prefix and Escape Scanner

This block sits at the front of a variable-length instruction decoder. It accepts one byte per cycle over a valid/ready handshake. It consumes any leading legacy prefix bytes, an optional register-extension byte (64-bit mode only) and opcode escape sequences. When it reaches the primary opcode byte, it presents one decoded record downstream. The record holds:
- the lock flag, the segment-override code and the operand-size and address-size override flags;
- the four extension bits;
- the opcode map and the captured escape payload;
- the opcode byte;
- the operand and address sizes that result for the configured 32-bit or 64-bit mode.

The record is held until the consumer takes it. While a record is pending, the input side stalls. A locked instruction raises a bus-lock output that stays high until the execution side reports that the instruction has completed. If a run of non-opcode bytes grows too long, the block flags an error and starts over with a clean state.

Top module: `pfx_scan`

## Requirements
- R1: After reset, out_valid, bus_lock and err are 0 and in_ready is 1.
- R2: The record appears with out_valid=1 in the cycle after the opcode byte is accepted. While out_valid=1 and out_ready=0, every record field holds its value and in_ready stays 0. The record is released at the edge where out_ready=1.
- R3: Segment prefixes set out_seg: 0x26 gives 1, 0x2E gives 2, 0x36 gives 3, 0x3E gives 4, 0x64 gives 5 and 0x65 gives 6. With no segment prefix out_seg is 0. When several segment prefixes appear, the last one seen wins.
- R4: out_opsz uses the codes 1=16-bit, 2=32-bit and 3=64-bit. The default is 2. Byte 0x66 sets out_opsz_ovr and gives 1. In 64-bit mode a retained extension byte with bit 3 set gives 3, even when 0x66 is present.
- R5: out_adsz uses the same codes as out_opsz. In 32-bit mode it is 2, or 1 with byte 0x67. In 64-bit mode it is 3, or 2 with byte 0x67. Byte 0x67 also sets out_adsz_ovr.
- R6: In 64-bit mode a byte 0x40..0x4F before the opcode sets out_rex_vld, and out_rex takes its bits 3..0. In 32-bit mode such a byte is the opcode, with map 0 and out_rex_vld=0.
- R7: An extension byte followed by a legacy prefix (0xF0, a segment byte, 0x66 or 0x67) is discarded, so out_rex_vld=0 and out_rex=0. An extension byte followed by an escape or by the opcode is kept.
- R8: out_map is 0 for a one-byte opcode and 1 after 0x0F. It is 2 after 0x0F 0x38 and 3 after 0x0F 0x3A. For maps 2 and 3, the byte after the second escape byte is the opcode.
- R9: 0xC5 gives map 4 and one payload byte in out_esc_pay[7:0], with [15:8]=0. 0xC4 gives map 5 and 0x8F gives map 6. Each of these takes two payload bytes: the first goes to [15:8] and the second to [7:0]. The byte after the payload is the opcode. out_esc_pay is 0 when there is no such escape.
- R10: 0xF0 sets out_lock. bus_lock rises together with out_valid for a locked instruction. It stays 1 after the record is taken, until an edge where instr_done=1.
- R11: At most 15 non-opcode bytes are allowed per instruction. When a 16th is accepted, err is 1 for one cycle and no record is produced. That byte and the partial state are dropped, and the next byte starts a new instruction.
- R12: No flag, code or payload of one instruction carries into the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode64 | input | 1 | 1 selects 64-bit mode; change only while idle |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Block can accept a byte |
| out_valid | output | 1 | Record valid |
| out_ready | input | 1 | Consumer takes the record |
| out_lock | output | 1 | Lock prefix present |
| out_seg | output | 3 | Segment override code |
| out_opsz_ovr | output | 1 | Operand-size override present |
| out_adsz_ovr | output | 1 | Address-size override present |
| out_rex_vld | output | 1 | Extension byte retained |
| out_rex | output | 4 | Extension bits W,R,X,B (3..0) |
| out_map | output | 3 | Opcode map code |
| out_esc_pay | output | 16 | Escape payload bytes |
| out_opcode | output | 8 | Primary opcode byte |
| out_opsz | output | 2 | Effective operand size code |
| out_adsz | output | 2 | Effective address size code |
| bus_lock | output | 1 | Bus lock held for a locked instruction |
| instr_done | input | 1 | Locked instruction has completed |
| err | output | 1 | Too many non-opcode bytes |

## Verification
A wrong scan state shows up in the record of the instruction it affects, one cycle after the opcode byte. Examples are a missed escape, a stale extension byte or a payload counter that is off by one. In the last case the wrong byte lands in out_opcode or in out_map. A flag left over from an earlier instruction shows up in the next instruction's record, so back-to-back random instructions with mixed prefixes are compared field by field. A faulty byte counter shows either as a missing err pulse on the sixteenth non-opcode byte, or as a spurious pulse on a legal fifteen-byte instruction. A faulty lock holder shows on bus_lock in the cycles between the record handshake and instr_done.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    typedef enum logic [2:0] {
        MAP_PRI  = 3'd0,
        MAP_0F   = 3'd1,
        MAP_0F38 = 3'd2,
        MAP_0F3A = 3'd3,
        MAP_VEX2 = 3'd4,
        MAP_VEX3 = 3'd5,
        MAP_XOP  = 3'd6
    } map_e;

    typedef enum logic [2:0] {
        SEG_NONE = 3'd0,
        SEG_ES   = 3'd1,
        SEG_CS   = 3'd2,
        SEG_SS   = 3'd3,
        SEG_DS   = 3'd4,
        SEG_FS   = 3'd5,
        SEG_GS   = 3'd6
    } seg_e;

    typedef enum logic [1:0] {
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } size_e;

    typedef enum logic [2:0] {
        ST_SCAN  = 3'd0,
        ST_ESC0F = 3'd1,
        ST_PAY   = 3'd2,
        ST_OPC   = 3'd3,
        ST_HOLD  = 3'd4
    } scan_st_e;

    typedef struct packed {
        logic is_legacy;
        logic is_lock;
        logic is_seg;
        seg_e seg;
        logic is_opsz;
        logic is_adsz;
        logic is_rex;
        logic is_0f;
        logic is_vex2;
        logic is_vex3;
        logic is_xop;
    } cls_t;

endpackage

// File: rtl/pfx_classify.sv
module pfx_classify
    import pfx_pkg::*;
(
    input  logic [7:0] byte_i,
    input  logic       mode64_i,
    output cls_t       cls_o
);

    always_comb begin
        cls_o = '0;
        case (byte_i)
            8'hF0: cls_o.is_lock = 1'b1;
            8'h26: begin cls_o.is_seg = 1'b1; cls_o.seg = SEG_ES; end
            8'h2E: begin cls_o.is_seg = 1'b1; cls_o.seg = SEG_CS; end
            8'h36: begin cls_o.is_seg = 1'b1; cls_o.seg = SEG_SS; end
            8'h3E: begin cls_o.is_seg = 1'b1; cls_o.seg = SEG_DS; end
            8'h64: begin cls_o.is_seg = 1'b1; cls_o.seg = SEG_FS; end
            8'h65: begin cls_o.is_seg = 1'b1; cls_o.seg = SEG_GS; end
            8'h66: cls_o.is_opsz = 1'b1;
            8'h67: cls_o.is_adsz = 1'b1;
            8'h0F: cls_o.is_0f   = 1'b1;
            8'hC5: cls_o.is_vex2 = 1'b1;
            8'hC4: cls_o.is_vex3 = 1'b1;
            8'h8F: cls_o.is_xop  = 1'b1;
            default: cls_o.is_rex = mode64_i && (byte_i[7:4] == 4'h4);
        endcase
        cls_o.is_legacy = cls_o.is_lock | cls_o.is_seg | cls_o.is_opsz | cls_o.is_adsz;
    end

endmodule

// File: rtl/pfx_size_resolve.sv
module pfx_size_resolve
    import pfx_pkg::*;
(
    input  logic  mode64_i,
    input  logic  opsz_ovr_i,
    input  logic  adsz_ovr_i,
    input  logic  rex_w_i,
    output size_e opsz_o,
    output size_e adsz_o
);

    always_comb begin
        if (mode64_i && rex_w_i) begin
            opsz_o = SZ_64;
        end else if (opsz_ovr_i) begin
            opsz_o = SZ_16;
        end else begin
            opsz_o = SZ_32;
        end
        if (mode64_i) begin
            adsz_o = adsz_ovr_i ? SZ_32 : SZ_64;
        end else begin
            adsz_o = adsz_ovr_i ? SZ_16 : SZ_32;
        end
    end

endmodule

// File: rtl/pfx_lock_hold.sv
module pfx_lock_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic lock_o
);

    logic lock_d, lock_q;

    always_comb begin
        lock_d = lock_q;
        if (clr_i) lock_d = 1'b0;
        if (set_i) lock_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= 1'b0;
        else        lock_q <= lock_d;
    end

    assign lock_o = lock_q;

    p_lock_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q && !clr_i |=> lock_q)
        else $error("bus lock dropped without completion");

    p_lock_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i && !set_i |=> !lock_q)
        else $error("bus lock not released on completion");

endmodule

// File: rtl/pfx_scan.sv
module pfx_scan
    import pfx_pkg::*;
#(
    parameter int MAX_PFX = 15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode64,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    output logic        in_ready,
    output logic        out_valid,
    input  logic        out_ready,
    output logic        out_lock,
    output logic [2:0]  out_seg,
    output logic        out_opsz_ovr,
    output logic        out_adsz_ovr,
    output logic        out_rex_vld,
    output logic [3:0]  out_rex,
    output logic [2:0]  out_map,
    output logic [15:0] out_esc_pay,
    output logic [7:0]  out_opcode,
    output logic [1:0]  out_opsz,
    output logic [1:0]  out_adsz,
    output logic        bus_lock,
    input  logic        instr_done,
    output logic        err
);

    localparam int CW = $clog2(MAX_PFX + 1);

    typedef struct packed {
        scan_st_e    st;
        logic        lock;
        seg_e        seg;
        logic        opsz;
        logic        adsz;
        logic        rex_vld;
        logic [3:0]  rex;
        map_e        map;
        logic [1:0]  pay_left;
        logic [15:0] pay;
        logic [7:0]  opc;
        logic [CW-1:0] cnt;
        logic        err;
    } scan_t;

    scan_t q, d;
    cls_t  cls;
    logic  acc, non_op, fin, set_lock;
    size_e opsz_w, adsz_w;

    pfx_classify u_cls (
        .byte_i   (in_byte),
        .mode64_i (mode64),
        .cls_o    (cls)
    );

    always_comb begin
        d        = q;
        d.err    = 1'b0;
        non_op   = 1'b0;
        fin      = 1'b0;
        set_lock = 1'b0;
        acc      = in_valid && (q.st != ST_HOLD);
        if (q.st == ST_HOLD) begin
            if (out_ready) d = '0;
        end else if (acc) begin
            case (q.st)
                ST_SCAN: begin
                    if (cls.is_legacy) begin
                        non_op    = 1'b1;
                        d.rex_vld = 1'b0;
                        d.rex     = 4'h0;
                        if (cls.is_lock) d.lock = 1'b1;
                        if (cls.is_seg)  d.seg  = cls.seg;
                        if (cls.is_opsz) d.opsz = 1'b1;
                        if (cls.is_adsz) d.adsz = 1'b1;
                    end else if (cls.is_rex) begin
                        non_op    = 1'b1;
                        d.rex_vld = 1'b1;
                        d.rex     = in_byte[3:0];
                    end else if (cls.is_0f) begin
                        non_op = 1'b1;
                        d.map  = MAP_0F;
                        d.st   = ST_ESC0F;
                    end else if (cls.is_vex2) begin
                        non_op     = 1'b1;
                        d.map      = MAP_VEX2;
                        d.pay_left = 2'd1;
                        d.st       = ST_PAY;
                    end else if (cls.is_vex3 || cls.is_xop) begin
                        non_op     = 1'b1;
                        d.map      = cls.is_xop ? MAP_XOP : MAP_VEX3;
                        d.pay_left = 2'd2;
                        d.st       = ST_PAY;
                    end else begin
                        fin = 1'b1;
                    end
                end
                ST_ESC0F: begin
                    if (in_byte == 8'h38) begin
                        non_op = 1'b1;
                        d.map  = MAP_0F38;
                        d.st   = ST_OPC;
                    end else if (in_byte == 8'h3A) begin
                        non_op = 1'b1;
                        d.map  = MAP_0F3A;
                        d.st   = ST_OPC;
                    end else begin
                        fin = 1'b1;
                    end
                end
                ST_PAY: begin
                    non_op     = 1'b1;
                    d.pay      = {q.pay[7:0], in_byte};
                    d.pay_left = q.pay_left - 2'd1;
                    if (q.pay_left == 2'd1) d.st = ST_OPC;
                end
                default: fin = 1'b1;
            endcase
            if (fin) begin
                d.opc    = in_byte;
                d.st     = ST_HOLD;
                set_lock = q.lock;
            end
            if (non_op) begin
                if (q.cnt == CW'(MAX_PFX)) begin
                    d     = '0;
                    d.err = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    pfx_size_resolve u_size (
        .mode64_i   (mode64),
        .opsz_ovr_i (q.opsz),
        .adsz_ovr_i (q.adsz),
        .rex_w_i    (q.rex_vld & q.rex[3]),
        .opsz_o     (opsz_w),
        .adsz_o     (adsz_w)
    );

    pfx_lock_hold u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_lock),
        .clr_i  (instr_done),
        .lock_o (bus_lock)
    );

    assign in_ready     = (q.st != ST_HOLD);
    assign out_valid    = (q.st == ST_HOLD);
    assign out_lock     = q.lock;
    assign out_seg      = q.seg;
    assign out_opsz_ovr = q.opsz;
    assign out_adsz_ovr = q.adsz;
    assign out_rex_vld  = q.rex_vld;
    assign out_rex      = q.rex;
    assign out_map      = q.map;
    assign out_esc_pay  = q.pay;
    assign out_opcode   = q.opc;
    assign out_opsz     = opsz_w;
    assign out_adsz     = adsz_w;
    assign err          = q.err;

    p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_opcode) && $stable(out_map)
                                    && $stable(out_esc_pay))
        else $error("record changed while stalled");

    p_no_take_while_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready)
        else $error("input accepted while record pending");

    p_rex_64_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !mode64 |-> !out_rex_vld)
        else $error("extension byte retained in 32-bit mode");

    p_w_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && mode64 && out_rex_vld && out_rex[3] |-> out_opsz == 2'd3)
        else $error("W bit did not select 64-bit operands");

    p_err_no_rec_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !out_valid && in_ready)
        else $error("error raised with a record pending");

    p_err_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err)
        else $error("error longer than one cycle");

    p_lock_with_rec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) && out_lock |-> bus_lock)
        else $error("bus lock missing for locked record");

endmodule

// File: tb/pfx_scan_bench.sv
module pfx_scan_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode64 = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic        out_lock;
    logic [2:0]  out_seg;
    logic        out_opsz_ovr;
    logic        out_adsz_ovr;
    logic        out_rex_vld;
    logic [3:0]  out_rex;
    logic [2:0]  out_map;
    logic [15:0] out_esc_pay;
    logic [7:0]  out_opcode;
    logic [1:0]  out_opsz;
    logic [1:0]  out_adsz;
    logic        bus_lock;
    logic        instr_done = 1'b0;
    logic        err;

    int errors = 0;
    int checks = 0;
    int err_seen = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfx_scan u_pfx_scan (
        .clk(clk), .rst_n(rst_n), .mode64(mode64),
        .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_lock(out_lock), .out_seg(out_seg),
        .out_opsz_ovr(out_opsz_ovr), .out_adsz_ovr(out_adsz_ovr),
        .out_rex_vld(out_rex_vld), .out_rex(out_rex), .out_map(out_map),
        .out_esc_pay(out_esc_pay), .out_opcode(out_opcode),
        .out_opsz(out_opsz), .out_adsz(out_adsz),
        .bus_lock(bus_lock), .instr_done(instr_done), .err(err)
    );

    always @(negedge clk) if (rst_n && err) err_seen++;

    typedef struct {
        bit       lock;
        int       seg;
        bit       o66;
        bit       a67;
        bit       rv;
        int       rex;
        int       map;
        int       pay;
        int       opc;
        int       opsz;
        int       adsz;
    } exp_t;

    logic [7:0] ib [0:31];
    int         ilen;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic exp_t model(input bit m64);
        exp_t e;
        int phase;
        int need;
        e = '{default: 0};
        phase = 0;
        need = 0;
        for (int i = 0; i < ilen; i++) begin
            logic [7:0] b;
            b = ib[i];
            if (phase == 0) begin
                case (b)
                    8'hF0: begin e.lock = 1; e.rv = 0; e.rex = 0; end
                    8'h26: begin e.seg = 1; e.rv = 0; e.rex = 0; end
                    8'h2E: begin e.seg = 2; e.rv = 0; e.rex = 0; end
                    8'h36: begin e.seg = 3; e.rv = 0; e.rex = 0; end
                    8'h3E: begin e.seg = 4; e.rv = 0; e.rex = 0; end
                    8'h64: begin e.seg = 5; e.rv = 0; e.rex = 0; end
                    8'h65: begin e.seg = 6; e.rv = 0; e.rex = 0; end
                    8'h66: begin e.o66 = 1; e.rv = 0; e.rex = 0; end
                    8'h67: begin e.a67 = 1; e.rv = 0; e.rex = 0; end
                    8'h0F: begin e.map = 1; phase = 1; end
                    8'hC5: begin e.map = 4; need = 1; phase = 2; end
                    8'hC4: begin e.map = 5; need = 2; phase = 2; end
                    8'h8F: begin e.map = 6; need = 2; phase = 2; end
                    default: begin
                        if (m64 && b[7:4] == 4'h4) begin e.rv = 1; e.rex = int'(b[3:0]); end
                        else e.opc = int'(b);
                    end
                endcase
            end else if (phase == 1) begin
                if (b == 8'h38)      begin e.map = 2; phase = 3; end
                else if (b == 8'h3A) begin e.map = 3; phase = 3; end
                else e.opc = int'(b);
            end else if (phase == 2) begin
                e.pay = ((e.pay & 8'hFF) << 8) | int'(b);
                need--;
                if (need == 0) phase = 3;
            end else begin
                e.opc = int'(b);
            end
        end
        e.opsz = (m64 && e.rv && e.rex[3]) ? 3 : (e.o66 ? 1 : 2);
        e.adsz = m64 ? (e.a67 ? 2 : 3) : (e.a67 ? 1 : 2);
        return e;
    endfunction

    function automatic bit special(input logic [7:0] b, input bit m64);
        case (b)
            8'hF0, 8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65,
            8'h66, 8'h67, 8'h0F, 8'hC5, 8'hC4, 8'h8F: return 1'b1;
            default: return m64 && (b[7:4] == 4'h4);
        endcase
    endfunction

    task automatic put_byte(input logic [7:0] b);
        in_byte  = b;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_instr(input int stall);
        exp_t e;
        e = model(mode64);
        for (int i = 0; i < ilen; i++) put_byte(ib[i]);
        check("R2 valid after opcode", int'(out_valid), 1);
        check("R2 in_ready low", int'(in_ready), 0);
        for (int s = 0; s <= stall; s++) begin
            check("R2 opcode held", int'(out_opcode), e.opc);
            check("R8 R9 map", int'(out_map), e.map);
            check("R9 payload", int'(out_esc_pay), e.pay);
            check("R3 segment", int'(out_seg), e.seg);
            check("R4 operand size", int'(out_opsz), e.opsz);
            check("R4 size flag", int'(out_opsz_ovr), int'(e.o66));
            check("R5 address size", int'(out_adsz), e.adsz);
            check("R5 address flag", int'(out_adsz_ovr), int'(e.a67));
            check("R6 R7 rex valid", int'(out_rex_vld), int'(e.rv));
            check("R6 R7 rex bits", int'(out_rex), e.rex);
            check("R10 lock flag", int'(out_lock), int'(e.lock));
            check("R10 bus lock", int'(bus_lock), int'(e.lock));
            if (s < stall) @(negedge clk);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check("R2 released", int'(out_valid), 0);
        check("R10 lock held after take", int'(bus_lock), int'(e.lock));
        if (e.lock) begin
            instr_done = 1'b1;
            @(negedge clk);
            instr_done = 1'b0;
            check("R10 lock cleared by done", int'(bus_lock), 0);
        end
    endtask

    task automatic set1(input logic [7:0] a);
        ib[0] = a; ilen = 1;
    endtask
    task automatic add(input logic [7:0] a);
        ib[ilen] = a; ilen++;
    endtask

    task automatic rand_instr(input bit m64);
        int np;
        int esc;
        logic [7:0] b;
        ilen = 0;
        np = $urandom_range(0, 5);
        for (int i = 0; i < np; i++) begin
            int k;
            k = $urandom_range(0, 10);
            case (k)
                0: add(8'hF0); 1: add(8'h26); 2: add(8'h2E); 3: add(8'h36);
                4: add(8'h3E); 5: add(8'h64); 6: add(8'h65); 7: add(8'h66);
                8: add(8'h67);
                default: add(m64 ? (8'h40 | 8'($urandom_range(0, 15))) : 8'h66);
            endcase
        end
        if (m64 && $urandom_range(0, 1) == 1) add(8'h40 | 8'($urandom_range(0, 15)));
        esc = $urandom_range(0, 6);
        case (esc)
            1: add(8'h0F);
            2: begin add(8'h0F); add(8'h38); end
            3: begin add(8'h0F); add(8'h3A); end
            4: begin add(8'hC5); add(8'($urandom)); end
            5: begin add(8'hC4); add(8'($urandom)); add(8'($urandom)); end
            6: begin add(8'h8F); add(8'($urandom)); add(8'($urandom)); end
            default: ;
        endcase
        do b = 8'($urandom); while ((esc == 0 || esc == 1) && special(b, m64) ||
                                    (esc == 1 && (b == 8'h38 || b == 8'h3A)));
        add(b);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int e0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 in_ready", int'(in_ready), 1);
        check("R1 bus_lock", int'(bus_lock), 0);
        check("R1 err", int'(err), 0);

        mode64 = 1'b0;
        set1(8'h66); add(8'h67); add(8'h8B); run_instr(0);
        set1(8'h48); run_instr(0);
        set1(8'h26); add(8'h65); add(8'h2E); add(8'h8B); run_instr(2);
        set1(8'hF0); add(8'h01); run_instr(3);
        set1(8'h90); run_instr(0);

        mode64 = 1'b1;
        @(negedge clk);
        set1(8'h66); add(8'h48); add(8'hC7); run_instr(0);
        set1(8'h48); add(8'h66); add(8'hC7); run_instr(0);
        set1(8'h4C); add(8'h0F); add(8'hAF); run_instr(0);
        set1(8'h0F); add(8'h38); add(8'h00); run_instr(0);
        set1(8'h0F); add(8'h3A); add(8'h0F); run_instr(1);
        set1(8'h0F); add(8'h05); run_instr(0);
        set1(8'hC4); add(8'hE3); add(8'h71); add(8'h4B); run_instr(0);
        set1(8'hC5); add(8'hF8); add(8'h77); run_instr(0);
        set1(8'h8F); add(8'hE8); add(8'h78); add(8'hC0); run_instr(0);
        set1(8'h67); add(8'h8B); run_instr(0);

        e0 = err_seen;
        ilen = 0;
        for (int i = 0; i < 15; i++) add(8'h66);
        add(8'h90);
        run_instr(0);
        check("R11 no error at limit", err_seen - e0, 0);

        e0 = err_seen;
        for (int i = 0; i < 16; i++) put_byte(i == 0 ? 8'hF0 : 8'h66);
        check("R11 err pulse", int'(err), 1);
        check("R11 no record", int'(out_valid), 0);
        @(negedge clk);
        check("R11 err one cycle", int'(err), 0);
        check("R11 one error", err_seen - e0, 1);
        set1(8'h90); run_instr(0);
        check("R12 no carry bus_lock", int'(bus_lock), 0);

        for (int m = 0; m < 2; m++) begin
            mode64 = (m == 1);
            @(negedge clk);
            for (int n = 0; n < 250; n++) begin
                rand_instr(mode64);
                run_instr($urandom_range(0, 2));
            end
        end
        check("R11 no spurious error", err_seen - e0, 1);
        finish_run();
    end

endmodule